// File: doc/BRIEF.md
# Upset-Masking Scan Storage Word

This block is a word of storage cells in which the scan portion of each cell does useful work during normal operation. Every bit holds two copies of its functional value. One is the system flip-flop and the other is the scan register. A consensus stage combines the two copies. When they match, the stage passes the shared value to the output. When they differ, a keeper register keeps the output at its last value. A transient upset that inverts only one copy therefore never reaches the output, and the two copies agree again at the next clock edge.

In test mode the scan registers of all bits form one serial chain with scan-in, scan-out, capture and update controls, and they behave as an ordinary scan element. In this mode the consensus stage is bypassed, and the functional output follows the system flip-flop alone. Two inputs, one per copy, invert the value that copy loads at a clock edge. They model particle strikes for verification. The two non-overlapping scan phases are modelled as a single clock edge.

Top module: `ser_resilient_cell`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, both copies, the keeper and the update register are cleared, so after that edge `q`, `so` and `upd_q` are all zero.
- R2: In functional mode (`test_en`=0) with no upset, `q` equals the `d` that was sampled at the previous rising edge.
- R3: In functional mode, a bit whose system copy alone is upset (`upset_sys` bit high at an edge) keeps its previous `q` value after that edge.
- R4: In functional mode, a bit whose scan copy alone is upset (`upset_scan` bit high at an edge) keeps its previous `q` value after that edge.
- R5: After an upset of a single copy, the first edge with no upset reloads both copies from `d`, so the copies agree and `q` equals that `d`.
- R6: A bit upset in both copies at the same edge shows the inverted `d` bit on `q`. This is the limit of the masking.
- R7: In test mode, `q` equals the system copy: the sampled `d` inverted on the bits where `upset_sys` was high. Upsets of the scan copy have no effect on `q`.
- R8: In test mode with `scan_shift`=1, the scan chain shifts by one bit towards the most significant bit. Bit 0 loads `si`, and `so` presents bit WIDTH-1.
- R9: In test mode with `scan_capture`=1 and `scan_shift`=0, the scan register loads `d`.
- R10: In test mode, `scan_update`=1 copies the scan register into `upd_q`. Otherwise `upd_q` holds its value.
- R11: In test mode, a shift takes priority over a capture when both are requested.
- R12: In functional mode, `scan_shift`, `scan_capture` and `scan_update` are ignored. The scan register loads `d` (visible on `so` as `d[WIDTH-1]`), and `upd_q` holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| test_en | input | 1 | 1 selects test mode, 0 selects functional mode |
| scan_shift | input | 1 | Shift the scan chain (test mode) |
| scan_capture | input | 1 | Capture `d` into the scan chain (test mode) |
| scan_update | input | 1 | Copy the scan chain into `upd_q` (test mode) |
| d | input | WIDTH | Functional data in |
| si | input | 1 | Serial scan in, to bit 0 |
| upset_sys | input | WIDTH | Invert the value the system copy loads, per bit |
| upset_scan | input | WIDTH | Invert the value the scan copy loads, per bit |
| q | output | WIDTH | Functional output after consensus or bypass |
| so | output | 1 | Serial scan out, from bit WIDTH-1 |
| upd_q | output | WIDTH | Update register contents |

## Verification
The bench builds the block with WIDTH=8. At this width a one-hot upset can be placed on the end bits as well as an interior bit, and single and double upsets can share one word. A captured byte pattern needs a full eight shifts to leave through `so`, which exercises the chain ordering from end to end. Random sparse upset masks on both copies cover mixed single, double and clean bits in the same cycle.

// File: rtl/ser_pkg.sv
// Package: shared types for the upset-masking scan storage word.
// Assumes: test mode and scan controls are sampled on the same clock edge.
package ser_pkg;

    // Action of the scan copy at a clock edge.
    typedef enum logic [1:0] {
        SCAN_HOLD    = 2'd0,
        SCAN_CAPTURE = 2'd1,
        SCAN_SHIFT   = 2'd2,
        SCAN_FUNC    = 2'd3
    } scan_op_e;

    // Decode mode and controls; shift wins over capture in test mode.
    function automatic scan_op_e decode_scan_op(input logic test,
                                                input logic shift,
                                                input logic capture);
        if (!test)        return SCAN_FUNC;
        else if (shift)   return SCAN_SHIFT;
        else if (capture) return SCAN_CAPTURE;
        else              return SCAN_HOLD;
    endfunction

endpackage

// File: rtl/ser_sys_copy.sv
// Module: system copy of the storage word.
// Loads d on every edge in both modes; a flip bit inverts the loaded value.
// Assumes: synchronous active-low reset.
module ser_sys_copy #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    input  logic [WIDTH-1:0] flip,
    output logic [WIDTH-1:0] sys_q
);

    // Purpose: functional capture with injected inversion.
    always_ff @(posedge clk) begin
        if (!rst_n) sys_q <= '0;
        else        sys_q <= d ^ flip;
    end

endmodule

// File: rtl/ser_scan_copy.sv
// Module: scan copy and update stage.
// Functional mode: mirrors d as the redundant copy. Test mode: shift chain
// (bit 0 from si, so from the top bit), capture of d, and an update register.
// Assumes: WIDTH >= 2; the two scan phases are folded into one edge.
module ser_scan_copy
    import ser_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  scan_op_e         op,
    input  logic             update_go,
    input  logic [WIDTH-1:0] d,
    input  logic             si,
    input  logic [WIDTH-1:0] flip,
    output logic [WIDTH-1:0] scan_q,
    output logic [WIDTH-1:0] upd_q,
    output logic             so
);

    localparam int TOP = WIDTH - 1;

    logic [WIDTH-1:0] load_val;

    // Purpose: select what the scan copy loads for the decoded action.
    always_comb begin
        unique case (op)
            SCAN_FUNC:    load_val = d;
            SCAN_CAPTURE: load_val = d;
            SCAN_SHIFT:   load_val = {scan_q[TOP-1:0], si};
            default:      load_val = scan_q;
        endcase
    end

    // Purpose: scan copy register with injected inversion.
    always_ff @(posedge clk) begin
        if (!rst_n) scan_q <= '0;
        else        scan_q <= load_val ^ flip;
    end

    // Purpose: update register, loaded only on a test-mode update.
    always_ff @(posedge clk) begin
        if (!rst_n)         upd_q <= '0;
        else if (update_go) upd_q <= scan_q;
    end

    assign so = scan_q[TOP];

endmodule

// File: rtl/ser_consensus.sv
// Module: per-bit consensus element with keeper.
// Passes the agreed value of two copies; holds the last output on
// disagreement; in bypass passes copy a alone. The keeper tracks the output.
// Assumes: synchronous active-low reset clears the keepers.
module ser_consensus #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bypass,
    input  logic [WIDTH-1:0] a,
    input  logic [WIDTH-1:0] b,
    output logic [WIDTH-1:0] y
);

    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
        logic keep_r;

        // Purpose: keeper follows the node so a disagreement freezes it.
        always_ff @(posedge clk) begin
            if (!rst_n) keep_r <= 1'b0;
            else        keep_r <= y[i];
        end

        assign y[i] = bypass ? a[i] : ((a[i] == b[i]) ? a[i] : keep_r);
    end

endmodule

// File: rtl/ser_resilient_cell.sv
// Module: upset-masking scan storage word (top).
// Each bit is stored twice (system copy and scan copy) and voted by a
// consensus element with keeper; test mode bypasses the vote.
// Assumes: WIDTH >= 2; upset inputs are used for fault injection only.
module ser_resilient_cell
    import ser_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             test_en,
    input  logic             scan_shift,
    input  logic             scan_capture,
    input  logic             scan_update,
    input  logic [WIDTH-1:0] d,
    input  logic             si,
    input  logic [WIDTH-1:0] upset_sys,
    input  logic [WIDTH-1:0] upset_scan,
    output logic [WIDTH-1:0] q,
    output logic             so,
    output logic [WIDTH-1:0] upd_q
);

    scan_op_e         scan_op;
    logic             update_go;
    logic [WIDTH-1:0] sys_vec;
    logic [WIDTH-1:0] scan_vec;

    assign scan_op   = decode_scan_op(test_en, scan_shift, scan_capture);
    assign update_go = test_en & scan_update;

    ser_sys_copy #(.WIDTH(WIDTH)) u_sys (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (d),
        .flip  (upset_sys),
        .sys_q (sys_vec)
    );

    ser_scan_copy #(.WIDTH(WIDTH)) u_scan (
        .clk       (clk),
        .rst_n     (rst_n),
        .op        (scan_op),
        .update_go (update_go),
        .d         (d),
        .si        (si),
        .flip      (upset_scan),
        .scan_q    (scan_vec),
        .upd_q     (upd_q),
        .so        (so)
    );

    ser_consensus #(.WIDTH(WIDTH)) u_vote (
        .clk    (clk),
        .rst_n  (rst_n),
        .bypass (test_en),
        .a      (sys_vec),
        .b      (scan_vec),
        .y      (q)
    );

endmodule

// File: rtl/ser_resilient_cell_chk.sv
// Module: assertion checker for ser_resilient_cell, attached by bind.
// Assumes: WIDTH >= 2.
module ser_resilient_cell_chk #(
    parameter int WIDTH = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             test_en,
    input logic             scan_shift,
    input logic             scan_capture,
    input logic             scan_update,
    input logic [WIDTH-1:0] d,
    input logic             si,
    input logic [WIDTH-1:0] upset_sys,
    input logic [WIDTH-1:0] upset_scan,
    input logic [WIDTH-1:0] q,
    input logic             so,
    input logic [WIDTH-1:0] upd_q,
    input logic [WIDTH-1:0] sys_vec,
    input logic [WIDTH-1:0] scan_vec
);

    AST_RESET_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> (q == '0 && so == 1'b0 && upd_q == '0)); // R1

    AST_FUNC_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !test_en && !$past(test_en) &&
         $past(upset_sys) == '0 && $past(upset_scan) == '0)
        |-> q == $past(d)); // R2

    AST_SINGLE_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !test_en && !$past(test_en))
        |-> ((q ^ $past(q)) & $past(upset_sys ^ upset_scan)) == '0); // R3 R4

    AST_COPIES_REAGREE: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(test_en) &&
         $past(upset_sys) == '0 && $past(upset_scan) == '0)
        |-> sys_vec == scan_vec); // R5

    AST_DOUBLE_PASSES: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !test_en && !$past(test_en))
        |-> ((q ^ ~$past(d)) & $past(upset_sys & upset_scan)) == '0); // R6

    AST_TEST_BYPASS: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && test_en) |-> q == $past(d ^ upset_sys)); // R7

    AST_SHIFT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(test_en && scan_shift))
        |-> scan_vec == ($past({scan_vec[WIDTH-2:0], si}) ^ $past(upset_scan))); // R8

    AST_CAPTURE_TAP: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(test_en && !scan_shift && scan_capture))
        |-> so == $past(d[WIDTH-1] ^ upset_scan[WIDTH-1])); // R9

    AST_UPDATE_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(test_en && scan_update))
        |-> upd_q == $past(scan_vec)); // R10

    AST_UPDATE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(test_en && scan_update))
        |-> $stable(upd_q)); // R12

endmodule

bind ser_resilient_cell ser_resilient_cell_chk #(.WIDTH(WIDTH)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .test_en      (test_en),
    .scan_shift   (scan_shift),
    .scan_capture (scan_capture),
    .scan_update  (scan_update),
    .d            (d),
    .si           (si),
    .upset_sys    (upset_sys),
    .upset_scan   (upset_scan),
    .q            (q),
    .so           (so),
    .upd_q        (upd_q),
    .sys_vec      (sys_vec),
    .scan_vec     (scan_vec)
);

// File: tb/sim_ser_resilient_cell.sv
`timescale 1ns/1ps
module sim_ser_resilient_cell;
    localparam int W = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0, test_en = 1'b0, scan_shift = 1'b0;
    logic scan_capture = 1'b0, scan_update = 1'b0, si = 1'b0;
    logic [W-1:0] d = '0, upset_sys = '0, upset_scan = '0;
    logic [W-1:0] q, upd_q;
    logic         so;

    int  n_cmp = 0;
    int  n_bad = 0;
    bit  finished = 1'b0;

    // Reference state, built from the requirements.
    logic [W-1:0] m_sys = '0, m_scan = '0, m_keep = '0, m_upd = '0;

    always #2 clk = ~clk;

    ser_resilient_cell #(.WIDTH(W)) u0 (
        .clk(clk), .rst_n(rst_n), .test_en(test_en), .scan_shift(scan_shift),
        .scan_capture(scan_capture), .scan_update(scan_update), .d(d), .si(si),
        .upset_sys(upset_sys), .upset_scan(upset_scan), .q(q), .so(so),
        .upd_q(upd_q)
    );

    function automatic logic [W-1:0] model_q();
        logic [W-1:0] r;
        for (int i = 0; i < W; i++) begin
            if (test_en)                r[i] = m_sys[i];
            else if (m_sys[i] == m_scan[i]) r[i] = m_sys[i];
            else                        r[i] = m_keep[i];
        end
        return r;
    endfunction

    task automatic cmp_vec(string req, string what, logic [W-1:0] got, logic [W-1:0] exp);
        n_cmp++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", req, what, got, exp);
        end
    endtask

    task automatic cmp_all(string req);
        cmp_vec(req, "q", q, model_q());
        cmp_vec(req, "so", {{(W-1){1'b0}}, so}, {{(W-1){1'b0}}, m_scan[W-1]});
        cmp_vec(req, "upd_q", upd_q, m_upd);
    endtask

    // One clock: advance the model, take the edge, compare at the falling edge.
    task automatic step(string req);
        logic [W-1:0] sys_n, scan_n, keep_n, upd_n, load;
        keep_n = model_q();
        if (!rst_n) begin
            sys_n = '0; scan_n = '0; keep_n = '0; upd_n = '0;
        end else begin
            sys_n = d ^ upset_sys;
            if (!test_en)        load = d;
            else if (scan_shift) load = {m_scan[W-2:0], si};
            else if (scan_capture) load = d;
            else                 load = m_scan;
            scan_n = load ^ upset_scan;
            upd_n  = (test_en && scan_update) ? m_scan : m_upd;
        end
        @(posedge clk);
        m_sys = sys_n; m_scan = scan_n; m_keep = keep_n; m_upd = upd_n;
        @(negedge clk);
        cmp_all(req);
    endtask

    task automatic clear_upsets();
        upset_sys = '0; upset_scan = '0;
    endtask

    task automatic finish_run();
        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_bad++;
            $display("FAIL WATCHDOG: actual hung run expected finish");
            finish_run();
        end
    end

    initial begin
        @(negedge clk);
        // R1: reset clears everything
        repeat (3) step("R1");
        cmp_vec("R1", "q after reset", q, 8'h00);
        rst_n = 1'b1;

        // R2: clean functional capture
        for (int k = 0; k < 20; k++) begin d = W'($urandom); step("R2"); end
        d = 8'hA5; step("R2");
        cmp_vec("R2", "q", q, 8'hA5);

        // R3: single system upset, then R5 recovery
        d = 8'h3C; step("R2");
        d = 8'hC3; upset_sys = 8'h01; step("R3");
        cmp_vec("R3", "q held bit0", q, 8'hC2);
        clear_upsets(); step("R5");
        cmp_vec("R5", "q reagree", q, 8'hC3);

        // R4: single scan upset, then R5 recovery
        d = 8'h00; upset_scan = 8'h80; step("R4");
        cmp_vec("R4", "q held bit7", q, 8'h80);
        clear_upsets(); step("R5");
        cmp_vec("R5", "q reagree", q, 8'h00);

        // R6: same bits upset in both copies pass through
        d = 8'h5A; upset_sys = 8'h0F; upset_scan = 8'h0F; step("R6");
        cmp_vec("R6", "q double upset", q, 8'h55);
        clear_upsets();

        // R3/R4/R6 mixed: sparse random upsets on both copies
        for (int k = 0; k < 40; k++) begin
            d = W'($urandom);
            upset_sys  = W'($urandom) & W'($urandom) & W'($urandom);
            upset_scan = W'($urandom) & W'($urandom) & W'($urandom);
            step("R4");
        end
        clear_upsets(); step("R5");

        // R12: scan controls ignored in functional mode
        scan_shift = 1'b1; scan_capture = 1'b1; scan_update = 1'b1;
        for (int k = 0; k < 6; k++) begin d = W'($urandom); step("R12"); end
        d = 8'h80; step("R12");
        cmp_vec("R12", "so is d top bit", {7'b0, so}, 8'h01);
        cmp_vec("R12", "upd_q held", upd_q, 8'h00);
        scan_shift = 1'b0; scan_capture = 1'b0; scan_update = 1'b0;

        // R9: capture in test mode
        test_en = 1'b1; scan_capture = 1'b1; d = 8'h96; step("R9");
        cmp_vec("R9", "so after capture", {7'b0, so}, 8'h01);

        // R8: shift the captured byte out, MSB first, shifting in alternating bits
        scan_capture = 1'b0; scan_shift = 1'b1;
        for (int k = 0; k < W; k++) begin si = k[0]; step("R8"); end

        // R11: shift beats capture
        scan_capture = 1'b1; si = 1'b1; d = 8'h00; step("R11");
        scan_shift = 1'b0; scan_capture = 1'b0;

        // R10: update copies the scan register
        scan_capture = 1'b1; d = 8'hE7; step("R9");
        scan_capture = 1'b0; scan_update = 1'b1; step("R10");
        cmp_vec("R10", "upd_q", upd_q, 8'hE7);
        scan_update = 1'b0; d = 8'h11; step("R10");
        cmp_vec("R10", "upd_q hold", upd_q, 8'hE7);

        // R7: bypass follows the system copy alone
        d = 8'h12; upset_scan = 8'hFF; step("R7");
        cmp_vec("R7", "q ignores scan upset", q, 8'h12);
        upset_scan = 8'h00; upset_sys = 8'h01; step("R7");
        cmp_vec("R7", "q shows system upset", q, 8'h13);
        clear_upsets();

        // Back to functional mode
        test_en = 1'b0;
        for (int k = 0; k < 10; k++) begin d = W'($urandom); step("R2"); end

        // R1: reset during operation
        rst_n = 1'b0; d = 8'hFF; step("R1");
        cmp_vec("R1", "q mid-run reset", q, 8'h00);
        rst_n = 1'b1;
        for (int k = 0; k < 4; k++) begin d = W'($urandom); step("R2"); end

        finish_run();
    end
endmodule